// File: doc/BRIEF.md
# Floppy head positioning controller

This block carries out the head-movement commands of a floppy disk controller. A command byte and a one-cycle start strobe launch one of five motions: return to track 0, seek to a target track, or a single step that repeats the last direction, goes inward or goes outward. While it runs, the block drives a direction level and a train of step pulses to the drive. Their spacing comes from a 2-bit rate field, measured by counting a one-per-microsecond clock enable.

The block holds the current track number, which software may load while the block is idle. A separate input carries the target track for a seek. The active-low track-zero signal from the drive ends a return-to-zero motion. Status gives busy, head-at-track-zero and seek-error flags. An interrupt flag rises when a command ends and stays up until the next command is accepted. A verify request bit is accepted and has no effect. A terminate input stops any motion at once.

Top module: `fhp_head_ctrl`

## Requirements
- R1: Command bits 7..4 select the operation: 0000 restore, 0001 seek, 001x step, 010x step-in, 011x step-out. A byte with bit 7 set is not accepted, and busy, irq, status and track stay as they were. `dir_out` high means inward, toward higher track numbers. Step pulses occur only while busy.
- R2: With `tick_us` high every clock, consecutive rising edges of `step_out` are exactly R*TICKS_PER_MS clocks apart, with R = 6, 12, 20, 30 ms for bits 1..0 = 0, 1, 2, 3. Each pulse lasts PULSE_TICKS clocks. `dir_out` does not change in the clock before a rising edge or while the pulse is high.
- R3: Restore samples `trk0_n` before every step. When it is low, the track register is cleared and the command ends. Otherwise the block steps outward. Restore never changes the track register while stepping.
- R4: If restore has issued RESTORE_LIMIT (255) steps and `trk0_n` is still high, it ends with the seek-error flag set and the track register unchanged. The flag is cleared when the next command is accepted.
- R5: Seek compares the track register with `target_trk`. While they differ, it steps toward the target and moves the track register one count per step. It ends when the two are equal, and issues no pulse if they are equal at the start.
- R6: Step, step-in and step-out each issue exactly one pulse. Step-in goes inward and step-out goes outward, and both record that direction. Step reuses the recorded direction, which is inward after reset. Restore and seek do not change the recorded direction.
- R7: For step, step-in and step-out, bit 4 (track update) set makes the track register count up on an inward pulse and down on an outward pulse, modulo 256. When the bit is clear, the register does not change. Bit 2 (verify) has no effect on any command.
- R8: `status` bit 0 is busy. Bit 2 is the inverse of `trk0_n`, registered one clock. Bit 4 is the seek error. All other bits read 0.
- R9: `irq` goes high in the clock in which busy falls at the end of a command. It stays high until the next accepted command start clears it.
- R10: `force_term` ends any command by the next clock edge: busy falls, `step_out` falls, `irq` is not raised and the track register keeps its value.
- R11: While busy, `cmd_start` and `trk_wr` are ignored. While idle, `trk_wr` loads `trk_wdata` into the track register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-microsecond clock enable |
| cmd_byte | input | 8 | Command byte |
| cmd_start | input | 1 | Start strobe for `cmd_byte` |
| force_term | input | 1 | Terminate the running command |
| trk_wr | input | 1 | Load the track register |
| trk_wdata | input | 8 | Value for the track register |
| target_trk | input | 8 | Target track for seek |
| trk0_n | input | 1 | Drive track-zero sense, active low |
| step_out | output | 1 | Step pulse to the drive |
| dir_out | output | 1 | Step direction, 1 = inward |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Command-complete interrupt |
| status | output | 8 | Status byte (bits 0, 2, 4 used) |
| track_q | output | 8 | Current track register |

## Verification
Internal faults in this block show up at the ports quickly:
- A wrong step counter or interval compare shows as a wrong gap between pulse edges, visible at the second pulse of any multi-step command.
- A wrong direction memory or decode shows as a wrong `dir_out` level at the first pulse.
- A wrong seek compare or track update shows in `track_q` and in the pulse count once `irq` rises, within one command.
- Terminate and ignore faults show in `busy` or `track_q` one clock after the stimulus.

// File: rtl/fhp_pkg.sv
package fhp_pkg;

    typedef enum logic [2:0] {
        OP_RESTORE,
        OP_SEEK,
        OP_STEP,
        OP_STEP_IN,
        OP_STEP_OUT,
        OP_NONE
    } op_e;

    typedef struct packed {
        op_e        op;
        logic       trk_upd;
        logic [1:0] rate;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECIDE,
        S_SETTLE,
        S_PULSE,
        S_WAIT
    } st_e;

    function automatic int unsigned rate_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 6;
            2'd1:    return 12;
            2'd2:    return 20;
            default: return 30;
        endcase
    endfunction

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.rate    = b[1:0];
        c.trk_upd = b[4];
        if (b[7])
            c.op = OP_NONE;
        else if (b[6:5] == 2'b01)
            c.op = OP_STEP;
        else if (b[6:5] == 2'b10)
            c.op = OP_STEP_IN;
        else if (b[6:5] == 2'b11)
            c.op = OP_STEP_OUT;
        else if (b[4])
            c.op = OP_SEEK;
        else
            c.op = OP_RESTORE;
        return c;
    endfunction

endpackage

// File: rtl/fhp_cmd_decode.sv
module fhp_cmd_decode
    import fhp_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_t       cmd
);
    logic unused_bits;
    assign unused_bits = ^cmd_byte[3:2];
    assign cmd = decode_cmd(cmd_byte);
endmodule

// File: rtl/fhp_step_timer.sv
module fhp_step_timer #(
    parameter int CW          = 16,
    parameter int PULSE_TICKS = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clr,
    input  logic          run,
    input  logic [CW-1:0] interval,
    output logic          evt_rise,
    output logic          evt_fall,
    output logic          evt_end
);
    localparam logic [CW-1:0] PULSE_END = CW'(PULSE_TICKS);
    localparam logic [CW-1:0] TWO       = CW'(2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end

    assign evt_rise = tick && (cnt == '0);
    assign evt_fall = tick && (cnt == PULSE_END);
    assign evt_end  = tick && (cnt == (interval - TWO));
endmodule

// File: rtl/fhp_motion_fsm.sv
module fhp_motion_fsm
    import fhp_pkg::*;
#(
    parameter int TRK_W         = 8,
    parameter int RESTORE_LIMIT = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  cmd_t             cmd_in,
    input  logic             force_term,
    input  logic             trk_wr,
    input  logic [TRK_W-1:0] trk_wdata,
    input  logic [TRK_W-1:0] target,
    input  logic             trk0_n,
    input  logic             evt_rise,
    input  logic             evt_fall,
    input  logic             evt_end,
    output logic             tmr_clr,
    output logic             tmr_run,
    output cmd_t             cur,
    output logic [TRK_W-1:0] track_q,
    output logic             step_out,
    output logic             dir_out,
    output logic             busy,
    output logic             irq,
    output logic             seek_err
);
    localparam int SW = $clog2(RESTORE_LIMIT + 1);
    localparam logic [SW-1:0] LIMIT = SW'(RESTORE_LIMIT);

    st_e         state;
    logic [SW-1:0] nsteps;
    logic        last_dir;
    logic        step_dir;
    logic        upd;

    always_comb begin
        case (cur.op)
            OP_STEP_IN:  step_dir = 1'b1;
            OP_STEP_OUT: step_dir = 1'b0;
            default:     step_dir = last_dir;
        endcase
        case (cur.op)
            OP_RESTORE: upd = 1'b0;
            OP_SEEK:    upd = 1'b1;
            default:    upd = cur.trk_upd;
        endcase
    end

    assign tmr_clr = (state == S_DECIDE);
    assign tmr_run = (state == S_SETTLE) || (state == S_PULSE) || (state == S_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            cur      <= '{op: OP_NONE, trk_upd: 1'b0, rate: 2'd0};
            nsteps   <= '0;
            last_dir <= 1'b1;
            track_q  <= '0;
            step_out <= 1'b0;
            dir_out  <= 1'b0;
            busy     <= 1'b0;
            irq      <= 1'b0;
            seek_err <= 1'b0;
        end else if (force_term) begin
            state    <= S_IDLE;
            busy     <= 1'b0;
            step_out <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (trk_wr)
                        track_q <= trk_wdata;
                    if (cmd_start && cmd_in.op != OP_NONE) begin
                        cur      <= cmd_in;
                        busy     <= 1'b1;
                        irq      <= 1'b0;
                        seek_err <= 1'b0;
                        nsteps   <= '0;
                        state    <= S_DECIDE;
                    end
                end
                S_DECIDE: begin
                    case (cur.op)
                        OP_RESTORE: begin
                            if (!trk0_n) begin
                                track_q <= '0;
                                busy    <= 1'b0;
                                irq     <= 1'b1;
                                state   <= S_IDLE;
                            end else if (nsteps == LIMIT) begin
                                seek_err <= 1'b1;
                                busy     <= 1'b0;
                                irq      <= 1'b1;
                                state    <= S_IDLE;
                            end else begin
                                dir_out <= 1'b0;
                                state   <= S_SETTLE;
                            end
                        end
                        OP_SEEK: begin
                            if (track_q == target) begin
                                busy  <= 1'b0;
                                irq   <= 1'b1;
                                state <= S_IDLE;
                            end else begin
                                dir_out <= (target > track_q);
                                state   <= S_SETTLE;
                            end
                        end
                        default: begin
                            if (nsteps != '0) begin
                                busy  <= 1'b0;
                                irq   <= 1'b1;
                                state <= S_IDLE;
                            end else begin
                                dir_out  <= step_dir;
                                last_dir <= step_dir;
                                state    <= S_SETTLE;
                            end
                        end
                    endcase
                end
                S_SETTLE: begin
                    if (evt_rise) begin
                        step_out <= 1'b1;
                        nsteps   <= nsteps + 1'b1;
                        if (upd)
                            track_q <= dir_out ? track_q + 1'b1 : track_q - 1'b1;
                        state <= S_PULSE;
                    end
                end
                S_PULSE: begin
                    if (evt_fall) begin
                        step_out <= 1'b0;
                        state    <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (evt_end)
                        state <= S_DECIDE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fhp_head_ctrl.sv
module fhp_head_ctrl
    import fhp_pkg::*;
#(
    parameter int TICKS_PER_MS  = 1000,
    parameter int PULSE_TICKS   = 10,
    parameter int RESTORE_LIMIT = 255
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_start,
    input  logic       force_term,
    input  logic       trk_wr,
    input  logic [7:0] trk_wdata,
    input  logic [7:0] target_trk,
    input  logic       trk0_n,
    output logic       step_out,
    output logic       dir_out,
    output logic       busy,
    output logic       irq,
    output logic [7:0] status,
    output logic [7:0] track_q
);
    localparam int TRK_W   = 8;
    localparam int MAX_IV  = 30 * TICKS_PER_MS;
    localparam int CW      = $clog2(MAX_IV + 1);

    initial begin
        if (6 * TICKS_PER_MS < PULSE_TICKS + 3)
            $error("shortest step interval too short for pulse width");
    end

    cmd_t          cmd_dec;
    cmd_t          cur;
    logic          tmr_clr, tmr_run;
    logic          evt_rise, evt_fall, evt_end;
    logic          seek_err;
    logic          at_trk0;
    logic [CW-1:0] interval;

    fhp_cmd_decode u_dec (
        .cmd_byte (cmd_byte),
        .cmd      (cmd_dec)
    );

    assign interval = CW'(rate_ms(cur.rate) * TICKS_PER_MS);

    fhp_step_timer #(
        .CW          (CW),
        .PULSE_TICKS (PULSE_TICKS)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_us),
        .clr      (tmr_clr),
        .run      (tmr_run),
        .interval (interval),
        .evt_rise (evt_rise),
        .evt_fall (evt_fall),
        .evt_end  (evt_end)
    );

    fhp_motion_fsm #(
        .TRK_W         (TRK_W),
        .RESTORE_LIMIT (RESTORE_LIMIT)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_start  (cmd_start),
        .cmd_in     (cmd_dec),
        .force_term (force_term),
        .trk_wr     (trk_wr),
        .trk_wdata  (trk_wdata),
        .target     (target_trk),
        .trk0_n     (trk0_n),
        .evt_rise   (evt_rise),
        .evt_fall   (evt_fall),
        .evt_end    (evt_end),
        .tmr_clr    (tmr_clr),
        .tmr_run    (tmr_run),
        .cur        (cur),
        .track_q    (track_q),
        .step_out   (step_out),
        .dir_out    (dir_out),
        .busy       (busy),
        .irq        (irq),
        .seek_err   (seek_err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            at_trk0 <= 1'b0;
        else
            at_trk0 <= ~trk0_n;
    end

    assign status = {3'b000, seek_err, 1'b0, at_trk0, 1'b0, busy};
endmodule

// File: rtl/fhp_head_ctrl_chk.sv
module fhp_head_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       force_term,
    input logic       trk_wr,
    input logic       step_out,
    input logic       dir_out,
    input logic       busy,
    input logic       irq,
    input logic [7:0] status,
    input logic [7:0] track_q
);
    AST_DIR_SETTLED: assert property (@(posedge clk) disable iff (rst)
        $rose(step_out) |-> $stable(dir_out)); // R2

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
        (step_out && $past(step_out)) |-> $stable(dir_out)); // R2

    AST_STEP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        step_out |-> busy); // R1

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (rst)
        force_term |=> (!busy && !step_out)); // R10

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> !busy); // R9

    AST_SEEKERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        status[4] |-> !busy); // R4

    AST_TRACK_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(busy) && !$past(trk_wr)) |-> $stable(track_q)); // R11
endmodule

bind fhp_head_ctrl fhp_head_ctrl_chk u_chk (.*);

// File: tb/tb_fhp_head_ctrl.sv
module tb_fhp_head_ctrl;
    localparam int TPM = 2;
    localparam int PUL = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b1;
    logic [7:0] cmd_byte = '0;
    logic       cmd_start = 1'b0;
    logic       force_term = 1'b0;
    logic       trk_wr = 1'b0;
    logic [7:0] trk_wdata = '0;
    logic [7:0] target_trk = '0;
    logic       trk0_n;
    logic       step_out, dir_out, busy, irq;
    logic [7:0] status, track_q;

    int  head = 7;
    bit  last_dir_m = 1'b1;
    int  nchk = 0, nfail = 0;
    int  npulse = 0, bad_dir = 0, bad_per = 0, bad_wid = 0;
    int  cyc = 0, last_rise = -1, rise_cyc = 0;
    int  exp_period = 12;
    bit  exp_dir_m = 1'b0;
    bit  dir_en = 1'b0;
    bit  prev_s = 1'b0, prev_d = 1'b0;
    int  trk = 0;

    always #5 clk = ~clk;

    assign trk0_n = (head == 0) ? 1'b0 : 1'b1;

    fhp_head_ctrl #(.TICKS_PER_MS(TPM), .PULSE_TICKS(PUL)) dut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .cmd_byte(cmd_byte),
        .cmd_start(cmd_start), .force_term(force_term), .trk_wr(trk_wr),
        .trk_wdata(trk_wdata), .target_trk(target_trk), .trk0_n(trk0_n),
        .step_out(step_out), .dir_out(dir_out), .busy(busy), .irq(irq),
        .status(status), .track_q(track_q)
    );

    always @(negedge clk) begin
        cyc++;
        if (step_out && !prev_s) begin
            npulse++;
            if (dir_en && dir_out != exp_dir_m) bad_dir++;
            if (dir_out != prev_d) bad_dir++;
            if (last_rise >= 0 && cyc - last_rise != exp_period) bad_per++;
            last_rise = cyc;
            rise_cyc  = cyc;
            if (dir_out) head++;
            else if (head > 0) head--;
        end
        if (!step_out && prev_s && (cyc - rise_cyc != PUL)) bad_wid++;
        prev_s = step_out;
        prev_d = dir_out;
    end

    function automatic int ms_of(input logic [1:0] c);
        case (c)
            2'd0: return 6;
            2'd1: return 12;
            2'd2: return 20;
            default: return 30;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    endtask

    initial begin
        #1900000;
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic issue(input logic [7:0] c);
        @(negedge clk);
        cmd_byte  = c;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 40000 && !irq; i++) @(negedge clk);
    endtask

    task automatic load_trk(input int v);
        @(negedge clk);
        trk_wr = 1'b1; trk_wdata = 8'(v);
        @(negedge clk);
        trk_wr = 1'b0;
        trk = v;
    endtask

    task automatic arm(input logic [7:0] c, input bit ed, input bit en);
        npulse = 0; bad_dir = 0; bad_per = 0; bad_wid = 0; last_rise = -1;
        exp_period = ms_of(c[1:0]) * TPM;
        exp_dir_m = ed; dir_en = en;
    endtask

    task automatic run_cmd(input logic [7:0] c, input int ep, input int etrk,
                           input int eerr, input bit ed, input bit en, input string tag);
        arm(c, ed, en);
        issue(c);
        wait_irq();
        chk({tag, " pulses"}, npulse, ep);
        chk({tag, " track"}, int'(track_q), etrk & 255);
        chk("R4 seek error flag", int'(status[4]), eerr);
        chk("R8 busy bit", int'(status[0]), 0);
        chk("R9 irq at end", int'(irq), 1);
        chk("R2 direction", bad_dir, 0);
        chk("R2 period", bad_per, 0);
        chk("R2 width", bad_wid, 0);
        chk("R8 track0 bit", int'(status[2]), (head == 0) ? 1 : 0);
        chk("R8 unused bits", int'(status & 8'hEA), 0);
        trk = etrk & 255;
    endtask

    task automatic do_restore(input logic [1:0] r, input bit v);
        logic [7:0] c;
        c = {4'b0000, 1'b1, v, r};
        if (head <= 255) run_cmd(c, head, 0, 0, 1'b0, 1'b1, "R3 restore");
        else             run_cmd(c, 255, trk, 1, 1'b0, 1'b1, "R4 restore timeout");
    endtask

    task automatic do_seek(input int tgt, input logic [1:0] r, input bit v);
        int d;
        target_trk = 8'(tgt);
        d = (tgt > trk) ? tgt - trk : trk - tgt;
        run_cmd({4'b0001, 1'b1, v, r}, d, tgt, 0, (tgt > trk), (d > 0), "R5 seek");
    endtask

    task automatic do_step(input int kind, input bit t, input logic [1:0] r, input bit v);
        logic [7:0] c;
        bit d;
        if (kind == 0) begin c = {3'b001, t, 1'b1, v, r}; d = last_dir_m; end
        else if (kind == 1) begin c = {3'b010, t, 1'b1, v, r}; d = 1'b1; end
        else begin c = {3'b011, t, 1'b1, v, r}; d = 1'b0; end
        last_dir_m = d;
        run_cmd(c, 1, t ? (d ? trk + 1 : trk + 255) : trk, 0, d, 1'b1, "R7 R6 step");
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset busy", int'(busy), 0);
        chk("R9 reset irq", int'(irq), 0);
        chk("R8 reset status", int'(status), 0);
        chk("R7 reset track", int'(track_q), 0);
        chk("R2 reset step", int'(step_out), 0);

        // R6: plain step after reset goes inward
        do_step(0, 1'b1, 2'd0, 1'b0);
        do_restore(2'd1, 1'b0);
        // R3: already at track zero, no pulses
        load_trk(40);
        do_restore(2'd0, 1'b1);
        do_seek(9, 2'd2, 1'b0);
        do_seek(9, 2'd3, 1'b1);
        do_seek(2, 2'd0, 1'b0);
        // R7: outward step from 0 wraps to 255; cleared update holds track
        load_trk(0);
        do_step(2, 1'b1, 2'd0, 1'b0);
        do_step(2, 1'b0, 2'd1, 1'b0);
        do_step(0, 1'b1, 2'd0, 1'b0);
        // R4: head beyond the step limit
        head = 300;
        load_trk(77);
        do_restore(2'd0, 1'b0);
        do_restore(2'd0, 1'b0);

        // R1: byte with bit 7 set is not accepted
        arm(8'hD0, 1'b0, 1'b0);
        issue(8'hD0);
        repeat (10) @(negedge clk);
        chk("R1 illegal busy", int'(busy), 0);
        chk("R1 illegal irq kept", int'(irq), 1);
        chk("R1 illegal pulses", npulse, 0);

        // R10: terminate mid seek
        load_trk(10);
        target_trk = 8'd60;
        arm(8'h10, 1'b1, 1'b1);
        issue(8'h10);
        chk("R9 irq cleared on start", int'(irq), 0);
        for (int i = 0; i < 5000 && npulse < 5; i++) @(negedge clk);
        force_term = 1'b1;
        @(negedge clk);
        force_term = 1'b0;
        chk("R10 busy after terminate", int'(busy), 0);
        chk("R10 step after terminate", int'(step_out), 0);
        chk("R10 irq after terminate", int'(irq), 0);
        repeat (60) @(negedge clk);
        chk("R10 no more pulses", npulse, 5);
        chk("R10 track kept", int'(track_q), 15);
        trk = 15;

        // R11: start and load while busy are ignored
        load_trk(20);
        target_trk = 8'd30;
        arm(8'h10, 1'b1, 1'b1);
        issue(8'h10);
        for (int i = 0; i < 5000 && npulse < 3; i++) @(negedge clk);
        cmd_byte = 8'h68; cmd_start = 1'b1; trk_wr = 1'b1; trk_wdata = 8'd99;
        @(negedge clk);
        cmd_start = 1'b0; trk_wr = 1'b0;
        wait_irq();
        chk("R11 pulses", npulse, 10);
        chk("R11 track", int'(track_q), 30);
        chk("R11 period", bad_per, 0);
        trk = 30;

        // mixed random commands
        for (int n = 0; n < 30; n++) begin
            int k, tgt;
            logic [1:0] r;
            bit t, v;
            k = int'($urandom % 5);
            r = 2'($urandom % 4);
            t = 1'($urandom % 2);
            v = 1'($urandom % 2);
            if ($urandom % 4 == 0) load_trk(int'($urandom % 200));
            if (k == 0) do_restore(r, v);
            else if (k == 1) begin
                tgt = trk + int'($urandom % 61) - 30;
                if (tgt < 0) tgt = 0;
                if (tgt > 255) tgt = 255;
                do_seek(tgt, r, v);
            end else do_step(k - 2, t, r, v);
        end

        finish_run();
    end
endmodule